// File: doc/BRIEF.md
# Two-Channel Byte-Lane Word Ring

This block keeps a circular buffer of 32-bit words that two byte-oriented channels share. Every word gives each channel one byte lane. Channel 0 uses bits 7:0 and channel 1 uses bits 15:8. Bits 31:16 always read as ones. A producer port writes one channel's bytes into its own lane, one word at a time. A consumer reads whole words in ring order, one word per strobe.

Each channel has an on/off control. When a channel changes state, its lane is refilled with 0xFF across the whole ring. When the producer has no more frame data, it can pad the rest of the current half of the ring with 0xFF in its lane.

The consumer raises an event as it passes the last word of each half. The event status tells software which half is free to refill. If an event repeats while its earlier instance is still uncleared, an overrun is reported. The consumer and the interrupt stay stopped and masked while both channels are off.

Top module: `bytelane_ring`

## Requirements
- R1: After reset, every word reads 0xFFFFFFFF, `rd_addr` is 0, `evt`, `ovr` and `irq` are 0, and both channels' write pointers are at word 0.
- R2: Channel 0's lane is bits 7:0 and channel 1's lane is bits 15:8. A byte write changes only its own lane of the addressed word, and bits 31:16 of `rd_word` are always ones.
- R3: Each channel has its own write pointer. The pointer advances by one word per accepted byte (`wr_valid` and `wr_ready` high, `wr_pad` low) and wraps from word DEPTH-1 to word 0.
- R4: When bit c of `ch_en` changes, the block refills lane c of every word with 0xFF. It then resets channel c's write pointer to word 0. `wr_ready` stays low while the refill is pending or in progress, and the other lane is untouched.
- R5: An accepted handshake with `wr_pad` high fills the selected lane with 0xFF. The fill runs from that channel's write pointer through the last word of the current half (word DEPTH/2-1 or DEPTH-1). The pointer then moves to the first word of the next half.
- R6: `rd_word` shows the word at `rd_addr`. `rd_addr` advances by one on each `rd_strobe`, wrapping after DEPTH-1, but only while at least one channel is on. Otherwise it holds.
- R7: A strobe at word DEPTH/2-1 sets `evt[0]` (first half free). A strobe at word DEPTH-1 sets `evt[1]` (second half free). Writing a one to a bit of `evt_clr` clears that bit, and a new event in the same cycle wins over the clear.
- R8: An event that arrives while its `evt` bit is set, and is not being cleared in that cycle, sets the matching `ovr` bit. `evt_clr` clears `ovr` bits as well.
- R9: `irq` is high only while at least one channel is on and some `evt` bit is set. It is masked while both channels are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 2 | Per-channel on/off control |
| wr_valid | input | 1 | Producer request valid |
| wr_ready | output | 1 | Producer request accepted this cycle |
| wr_ch | input | 1 | Producer channel select |
| wr_pad | input | 1 | Request is a pad to the end of the current half |
| wr_data | input | 8 | Producer byte |
| rd_strobe | input | 1 | Consumer advance strobe |
| rd_addr | output | log2(DEPTH) | Consumer word pointer |
| rd_word | output | 32 | Word at the consumer pointer |
| evt_clr | input | 2 | Write-one-to-clear for evt and ovr |
| evt | output | 2 | Half-free event status |
| ovr | output | 2 | Late-service overrun status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 16, so each half is eight words. Both half events, the consumer wrap and repeated passes that cause an overrun all fall within a few dozen strobes. Producer writes of more than sixteen bytes wrap a write pointer and overwrite older data. A pad from mid-half then shows a visible change against that data. A reference copy of the ring is kept from the requirements, and every consumer word is compared with it.

// File: rtl/bytelane_ring.sv
module bytelane_ring #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ch_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_ch,
  input  logic          wr_pad,
  input  logic [7:0]    wr_data,
  input  logic          rd_strobe,
  output logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_word,
  input  logic [1:0]    evt_clr,
  output logic [1:0]    evt,
  output logic [1:0]    ovr,
  output logic          irq
);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] HMSK = AW'(HALF - 1);

  logic [15:0]   mem [DEPTH];
  logic [1:0]    en_q, pend;
  logic [AW-1:0] wp [2];
  logic          busy, fch;
  logic [AW-1:0] fptr, fend;

  wire run  = |en_q;
  wire acc  = wr_valid && wr_ready;
  wire step = run && rd_strobe;
  wire [1:0] hit = {step && rd_addr == LAST, step && rd_addr == HMSK};
  wire       pc  = ~pend[0];

  assign wr_ready = !busy && pend == 2'b00;
  assign rd_word  = {16'hFFFF, mem[rd_addr]};
  assign irq      = run && evt != 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      en_q    <= '0;
      pend    <= '0;
      wp[0]   <= '0;
      wp[1]   <= '0;
      busy    <= 1'b0;
      fch     <= 1'b0;
      fptr    <= '0;
      fend    <= '0;
      rd_addr <= '0;
      evt     <= '0;
      ovr     <= '0;
    end else begin
      en_q <= ch_en;
      if (busy) begin
        mem[fptr] <= fch ? {8'hFF, mem[fptr][7:0]} : {mem[fptr][15:8], 8'hFF};
        if (fptr == fend) busy <= 1'b0;
        else fptr <= fptr + 1'b1;
      end else if (pend != 2'b00) begin
        busy     <= 1'b1;
        fch      <= pc;
        fptr     <= '0;
        fend     <= LAST;
        wp[pc]   <= '0;
        pend[pc] <= 1'b0;
      end else if (acc && wr_pad) begin
        busy      <= 1'b1;
        fch       <= wr_ch;
        fptr      <= wp[wr_ch];
        fend      <= wp[wr_ch] | HMSK;
        wp[wr_ch] <= (wp[wr_ch] | HMSK) + 1'b1;
      end else if (acc) begin
        mem[wp[wr_ch]] <= wr_ch ? {wr_data, mem[wp[wr_ch]][7:0]}
                                : {mem[wp[wr_ch]][15:8], wr_data};
        wp[wr_ch] <= wp[wr_ch] + 1'b1;
      end
      for (int c = 0; c < 2; c++)
        if (ch_en[c] != en_q[c]) pend[c] <= 1'b1;
      if (step) rd_addr <= rd_addr + 1'b1;
      evt <= (evt & ~evt_clr) | hit;
      ovr <= (ovr & ~evt_clr) | (hit & evt & ~evt_clr);
    end
  end
endmodule

module bytelane_ring_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          rd_strobe,
  input logic [AW-1:0] rd_addr,
  input logic [31:0]   rd_word,
  input logic [1:0]    evt_clr,
  input logic [1:0]    evt,
  input logic [1:0]    ovr,
  input logic          irq
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] HMSK = AW'(DEPTH / 2 - 1);

  AST_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n) rd_word[31:16] == 16'hFFFF); // R2
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(rd_addr)); // R6
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n) run && rd_strobe && rd_addr == LAST |=> rd_addr == '0); // R6
  AST_HALF_EVT: assert property (@(posedge clk) disable iff (!rst_n) run && rd_strobe && rd_addr == HMSK |=> evt[0]); // R7
  AST_END_EVT: assert property (@(posedge clk) disable iff (!rst_n) run && rd_strobe && rd_addr == LAST |=> evt[1]); // R7
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) run && rd_strobe && rd_addr == HMSK && evt[0] && !evt_clr[0] |=> ovr[0]); // R8
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !irq); // R9
endmodule

bind bytelane_ring bytelane_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
  .rd_word(rd_word), .evt_clr(evt_clr), .evt(evt), .ovr(ovr), .irq(irq)
);

// File: tb/bytelane_ring_bench.sv
module bytelane_ring_bench;
  localparam int D = 16;
  logic clk = 0, rst_n = 0;
  logic [1:0] ch_en = 0, evt_clr = 0, evt, ovr;
  logic wr_valid = 0, wr_ch = 0, wr_pad = 0, rd_strobe = 0, wr_ready, irq;
  logic [7:0] wr_data = 0;
  logic [3:0] rd_addr;
  logic [31:0] rd_word;

  bytelane_ring #(.DEPTH(D)) u_bytelane_ring (.*);

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, rp = 0;
  bit done = 0;
  string tag = "R1";
  logic [15:0] model [D];
  int wpm [2];
  logic [31:0] q [$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && rd_strobe && q.size() > 0) begin
      logic [31:0] e;
      e = q.pop_front();
      chk(rd_word == e, tag, rd_word, e);
    end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wait_ready(); @(negedge clk); while (!wr_ready) @(negedge clk); endtask

  task automatic put(input bit ch, input logic [7:0] d, input bit pad);
    wait_ready();
    wr_valid = 1; wr_ch = ch; wr_data = d; wr_pad = pad;
    tick();
    wr_valid = 0; wr_pad = 0;
    if (pad) begin
      for (int a = wpm[ch]; a <= (wpm[ch] | 7); a++)
        if (ch) model[a][15:8] = 8'hFF; else model[a][7:0] = 8'hFF;
      wpm[ch] = ((wpm[ch] | 7) + 1) % D;
    end else begin
      if (ch) model[wpm[ch]][15:8] = d; else model[wpm[ch]][7:0] = d;
      wpm[ch] = (wpm[ch] + 1) % D;
    end
  endtask

  task automatic pull();
    q.push_back({16'hFFFF, model[rp]});
    rd_strobe = 1;
    tick();
    rd_strobe = 0;
    rp = (rp + 1) % D;
  endtask

  task automatic set_en(input logic [1:0] v, input int lane);
    ch_en = v;
    tick(); tick();
    @(negedge clk);
    chk(wr_ready == 0, "R4", {31'd0, wr_ready}, 32'd0);
    for (int a = 0; a < D; a++)
      if (lane == 1) model[a][15:8] = 8'hFF; else model[a][7:0] = 8'hFF;
    wpm[lane] = 0;
    wait_ready();
  endtask

  task automatic clr(input logic [1:0] m);
    evt_clr = m; tick(); evt_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int a = 0; a < D; a++) model[a] = 16'hFFFF;
    wpm[0] = 0; wpm[1] = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    @(negedge clk);
    chk(rd_word == 32'hFFFFFFFF, "R1", rd_word, 32'hFFFFFFFF);
    chk(rd_addr == 0, "R1", {28'd0, rd_addr}, 0);
    chk({evt, ovr, irq} == 0, "R1", {27'd0, evt, ovr, irq}, 0);
    rd_strobe = 1; tick(); tick(); rd_strobe = 0;
    @(negedge clk);
    chk(rd_addr == 0, "R6", {28'd0, rd_addr}, 0);

    set_en(2'b01, 0);
    put(0, 8'h12, 0); put(0, 8'h34, 0); put(0, 8'h56, 0);
    set_en(2'b11, 1);
    put(1, 8'hA5, 0); put(1, 8'h5A, 0);

    tag = "R2";
    for (int i = 0; i < 8; i++) pull();
    @(negedge clk);
    chk(evt == 2'b01, "R7", {30'd0, evt}, 1);
    chk(irq == 1, "R9", {31'd0, irq}, 1);
    clr(2'b01);
    @(negedge clk);
    chk(evt == 2'b00, "R7", {30'd0, evt}, 0);
    for (int i = 0; i < 8; i++) pull();
    @(negedge clk);
    chk(evt == 2'b10, "R7", {30'd0, evt}, 2);
    chk(rd_addr == 0, "R6", {28'd0, rd_addr}, 0);
    for (int i = 0; i < 16; i++) pull();
    @(negedge clk);
    chk(evt == 2'b11, "R7", {30'd0, evt}, 3);
    chk(ovr == 2'b10, "R8", {30'd0, ovr}, 2);
    clr(2'b11);
    @(negedge clk);
    chk({evt, ovr} == 0, "R8", {28'd0, evt, ovr}, 0);

    tag = "R3";
    for (int i = 0; i < 16; i++) put(0, 8'h40 + 8'(i), 0);
    for (int i = 0; i < 16; i++) pull();
    tag = "R5";
    put(0, 8'h00, 1);
    put(0, 8'h77, 0);
    for (int i = 0; i < 16; i++) pull();
    clr(2'b11);

    set_en(2'b10, 0);
    tag = "R4";
    put(0, 8'h99, 0);
    for (int i = 0; i < 16; i++) pull();
    @(negedge clk);
    chk(evt == 2'b11, "R7", {30'd0, evt}, 3);

    set_en(2'b00, 1);
    @(negedge clk);
    chk(irq == 0 && evt != 0, "R9", {29'd0, irq, evt}, {29'd0, 1'b0, evt});
    rd_strobe = 1; tick(); tick(); rd_strobe = 0;
    @(negedge clk);
    chk(rd_addr == 4'(rp), "R6", {28'd0, rd_addr}, rp);
    chk(rd_word == {16'hFFFF, model[rp]}, "R4", rd_word, {16'hFFFF, model[rp]});
    chk(q.size() == 0, "R6", q.size(), 0);
    finish_run();
  end
endmodule